// File: doc/BRIEF.md
# Dual Timer and Watchdog Peripheral

This peripheral holds two general-purpose down-counters and one watchdog down-counter behind a small 32-bit register bus. A single control word holds a pair of bits per counter: one starts or stops it, and one chooses between a single countdown and repeated countdowns. A repeating counter that has reached zero restarts from its reload register. This makes it possible to build periodic tick sources. If the second timer is loaded with all ones and set to repeat, it becomes a free-running 32-bit counter. Software reads the bitwise inverse of that counter to get a timestamp that counts up.

Each general timer sets a sticky interrupt flag in the cycle its count reaches zero. Software clears the flag by writing a one to the matching status bit. When the watchdog count reaches zero, the block raises a reset request for one cycle. It does this only if the external reset-out enable input is high in that cycle. Software postpones a watchdog expiry by writing a fresh value into the watchdog count register.

Top module: `dualtmr_wdog`

## Requirements
- R1: After a synchronous reset, every register reads zero and `tmr_irq` and `wdog_rst_req` are low.
- R2: Register decode uses the word offset `bus_addr[5:2]`:
  - 0x00: control. Bits [5:0] are stored and read back; higher bits read zero.
  - 0x10 and 0x14: reload and count of timer0.
  - 0x18 and 0x1C: reload and count of timer1.
  - 0x20 and 0x24: reload and count of the watchdog.
  - 0x28: interrupt status. Bit0 is the timer0 flag and bit1 is the timer1 flag.
  - Control bit 2k starts counter k and bit 2k+1 makes it repeat, with k = 0 for timer0, 1 for timer1 and 2 for the watchdog.
- R3: A started counter with a nonzero count decreases by exactly one on every clock.
- R4: A started counter whose repeat bit is clear stays at zero once it gets there.
- R5: A started repeating counter at zero loads its reload value on the next clock, so its period is reload+1 cycles. With reload all ones it wraps from 0 to 0xFFFFFFFF, and its inverse rises by one per cycle.
- R6: A write to a count register sets that count on the next clock, whether the counter is started or not. This write takes priority over counting and reloading.
- R7: Writing zero to the control register stops all three counters, and each count then holds its value.
- R8: Each general timer sets its sticky interrupt flag (`tmr_irq[k]`) on the clock where its count goes from 1 to 0. Writing a one to status bit k clears flag k. If a set and a clear land on the same clock, the set wins.
- R9: When the watchdog count goes from 1 to 0 and `rst_out_en` is high on that clock, `wdog_rst_req` is high for exactly the following cycle. When `rst_out_en` is low, no request is raised.
- R10: Reads of offsets 0x04–0x0C, 0x2C and above, or of any address with `bus_addr[1:0]` nonzero, return zero. Writes to those addresses change nothing.
- R11: A stopped counter holds its count while the other counters keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | AW (6) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from `bus_addr` |
| rst_out_en | input | 1 | Permits the watchdog to raise its reset request |
| tmr_irq | output | NUM_GP (2) | Sticky interrupt flags of the general timers |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The case that is hardest to reach from the ports is a timer reaching zero on the very clock that a status clear write for its own flag arrives. The bench sets it up by writing a count of 2 into a running one-shot timer whose flag is already set. It then waits exactly one idle cycle and issues the clear on the next clock. A second case is a watchdog that is refreshed repeatedly just before it expires. The bench does this by rewriting the count at a fixed interval shorter than the count. It then stops refreshing and lets the watchdog run out twice, once with `rst_out_en` high and once with it low. A behavioural reference model follows every write and counter step, and it is compared with the outputs and with the read data on every clock.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    // Word offsets (byte offset / 4) that software decodes
    localparam int CTL_IDX  = 0;
    localparam int RLD_BASE = 4;
    localparam int CNT_BASE = 5;

    // Bit offsets inside each counter's pair of control bits
    localparam int EN_OFS  = 0;
    localparam int PER_OFS = 1;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_LOAD,
        CNT_DEC,
        CNT_RELOAD
    } cnt_act_e;

    // The status word follows the last count register
    function automatic int stat_idx(int num_cnt);
        return RLD_BASE + 2 * num_cnt;
    endfunction

endpackage

// File: rtl/dtw_down_counter.sv
module dtw_down_counter
    import dtw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         repeat_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_act_e   act;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;

        if (load_i) begin
            act = CNT_LOAD;
        end else if (!run_i) begin
            act = CNT_HOLD;
        end else if (st_q.cnt != '0) begin
            act = CNT_DEC;
        end else if (repeat_i) begin
            act = CNT_RELOAD;
        end else begin
            act = CNT_HOLD;
        end

        case (act)
            CNT_LOAD:   st_d.cnt = load_val_i;
            CNT_DEC: begin
                st_d.cnt = st_q.cnt - W'(1);
                hit_o    = (st_q.cnt == W'(1));
            end
            CNT_RELOAD: st_d.cnt = reload_i;
            default:    st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/dtw_regfile.sv
module dtw_regfile
    import dtw_pkg::*;
#(
    parameter int NUM_GP = 2,
    parameter int DW     = 32,
    parameter int AW     = 6,
    localparam int NT    = NUM_GP + 1,
    localparam int CTL_W = 2 * NT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic                   rst_out_en_i,
    input  logic [NT-1:0]          hit_i,
    input  logic [NT-1:0][DW-1:0]  cnt_i,
    output logic [DW-1:0]          rdata_o,
    output logic [CTL_W-1:0]       ctl_o,
    output logic [NT-1:0][DW-1:0]  rld_o,
    output logic [NT-1:0]          load_o,
    output logic [NUM_GP-1:0]      irq_o,
    output logic                   req_o
);

    localparam int IDX_W  = AW - 2;
    localparam int STAT_I = stat_idx(NT);

    typedef struct packed {
        logic [CTL_W-1:0]         ctl;
        logic [NT-1:0][DW-1:0]    rld;
        logic [NUM_GP-1:0]        flag;
        logic                     req;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              aligned;
    logic              wr_acc;
    logic [IDX_W-1:0]  idx;
    logic [NUM_GP-1:0] clr;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign wr_acc  = we_i && aligned;
    assign idx     = addr_i[AW-1:2];

    // Next-state of the software-visible registers
    always_comb begin
        regs_d = regs_q;
        load_o = '0;

        if (wr_acc && idx == IDX_W'(CTL_IDX)) begin
            regs_d.ctl = wdata_i[CTL_W-1:0];
        end

        for (int i = 0; i < NT; i++) begin
            if (wr_acc && idx == IDX_W'(RLD_BASE + 2 * i)) begin
                regs_d.rld[i] = wdata_i;
            end
            load_o[i] = wr_acc && (idx == IDX_W'(CNT_BASE + 2 * i));
        end

        if (wr_acc && idx == IDX_W'(STAT_I)) begin
            clr = wdata_i[NUM_GP-1:0];
        end else begin
            clr = '0;
        end

        // A new expiry outranks a clear in the same cycle
        regs_d.flag = (regs_q.flag & ~clr) | hit_i[NUM_GP-1:0];
        regs_d.req  = hit_i[NT-1] & rst_out_en_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read-back multiplexer; holes and misaligned addresses give zero
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (idx == IDX_W'(CTL_IDX)) begin
                rdata_o = DW'(regs_q.ctl);
            end
            if (idx == IDX_W'(STAT_I)) begin
                rdata_o = DW'(regs_q.flag);
            end
            for (int i = 0; i < NT; i++) begin
                if (idx == IDX_W'(RLD_BASE + 2 * i)) begin
                    rdata_o = regs_q.rld[i];
                end
                if (idx == IDX_W'(CNT_BASE + 2 * i)) begin
                    rdata_o = cnt_i[i];
                end
            end
        end
    end

    assign ctl_o = regs_q.ctl;
    assign rld_o = regs_q.rld;
    assign irq_o = regs_q.flag;
    assign req_o = regs_q.req;

endmodule

// File: rtl/dualtmr_wdog.sv
module dualtmr_wdog
    import dtw_pkg::*;
#(
    parameter int NUM_GP = 2,
    parameter int DW     = 32,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              rst_out_en,
    output logic [NUM_GP-1:0] tmr_irq,
    output logic              wdog_rst_req
);

    localparam int NT    = NUM_GP + 1;
    localparam int CTL_W = 2 * NT;

    logic [CTL_W-1:0]        ctl_w;
    logic [NT-1:0][DW-1:0]   cnt_w;
    logic [NT-1:0][DW-1:0]   rld_w;
    logic [NT-1:0]           load_w;
    logic [NT-1:0]           hit_w;

    dtw_regfile #(
        .NUM_GP (NUM_GP),
        .DW     (DW),
        .AW     (AW)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .we_i         (bus_we),
        .addr_i       (bus_addr),
        .wdata_i      (bus_wdata),
        .rst_out_en_i (rst_out_en),
        .hit_i        (hit_w),
        .cnt_i        (cnt_w),
        .rdata_o      (bus_rdata),
        .ctl_o        (ctl_w),
        .rld_o        (rld_w),
        .load_o       (load_w),
        .irq_o        (tmr_irq),
        .req_o        (wdog_rst_req)
    );

    // Counter slices: general timers first, watchdog last
    for (genvar g = 0; g < NT; g++) begin : g_cnt
        dtw_down_counter #(
            .W (DW)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .run_i      (ctl_w[2*g + EN_OFS]),
            .repeat_i   (ctl_w[2*g + PER_OFS]),
            .load_i     (load_w[g]),
            .load_val_i (bus_wdata),
            .reload_i   (rld_w[g]),
            .cnt_o      (cnt_w[g]),
            .hit_o      (hit_w[g])
        );
    end

endmodule

// File: rtl/dtw_checker.sv
module dtw_checker
    import dtw_pkg::*;
#(
    parameter int NUM_GP = 2,
    parameter int DW     = 32,
    parameter int AW     = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              rst_out_en,
    input logic [NUM_GP-1:0] tmr_irq,
    input logic              wdog_rst_req,
    input logic              t0_run,
    input logic              t0_rep,
    input logic              t1_run,
    input logic              t1_rep,
    input logic              wd_run,
    input logic [DW-1:0]     cnt0,
    input logic [DW-1:0]     cnt1,
    input logic [DW-1:0]     cntw,
    input logic [DW-1:0]     rld1
);

    localparam int NT    = NUM_GP + 1;
    localparam int IDX_W = AW - 2;

    logic             acc;
    logic [IDX_W-1:0] idx;
    logic             ld0, ld1, ldw;

    assign acc = bus_we && (bus_addr[1:0] == 2'b00);
    assign idx = bus_addr[AW-1:2];
    assign ld0 = acc && idx == IDX_W'(CNT_BASE);
    assign ld1 = acc && idx == IDX_W'(CNT_BASE + 2);
    assign ldw = acc && idx == IDX_W'(CNT_BASE + 2 * (NT - 1));

    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (t0_run && !ld0 && cnt0 != '0) |=> (cnt0 == $past(cnt0) - DW'(1)));

    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (t0_run && !t0_rep && !ld0 && cnt0 == '0) |=> (cnt0 == '0));

    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (t1_run && t1_rep && !ld1 && cnt1 == '0) |=> (cnt1 == $past(rld1)));

    a_r6_count_write: assert property (@(posedge clk) disable iff (rst)
        ldw |=> (cntw == $past(bus_wdata)));

    a_r11_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!wd_run && !ldw) |=> $stable(cntw));

    for (genvar g = 0; g < NUM_GP; g++) begin : g_irq
        logic clr_g;
        assign clr_g = acc && idx == IDX_W'(stat_idx(NT)) && bus_wdata[g];
        a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
            (tmr_irq[g] && !clr_g) |=> tmr_irq[g]);
    end

    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |-> $past(rst_out_en));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |=> !wdog_rst_req);

    a_r9_at_zero: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |-> (cntw == '0));

endmodule

bind dualtmr_wdog dtw_checker #(
    .NUM_GP (NUM_GP),
    .DW     (DW),
    .AW     (AW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .rst_out_en   (rst_out_en),
    .tmr_irq      (tmr_irq),
    .wdog_rst_req (wdog_rst_req),
    .t0_run       (ctl_w[0]),
    .t0_rep       (ctl_w[1]),
    .t1_run       (ctl_w[2]),
    .t1_rep       (ctl_w[3]),
    .wd_run       (ctl_w[2*NUM_GP]),
    .cnt0         (cnt_w[0]),
    .cnt1         (cnt_w[1]),
    .cntw         (cnt_w[NUM_GP]),
    .rld1         (rld_w[1])
);

// File: tb/dualtmr_wdog_tb.sv
module dualtmr_wdog_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_out_en = 1'b0;
    logic [1:0]  irq;
    logic        wreq;

    int n_cmp = 0;
    int n_bad = 0;
    int wd_pulses = 0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_cnt [3];
    logic [31:0] m_rld [3];
    logic [5:0]  m_ctl;
    logic [1:0]  m_flag;
    logic        m_req;

    dualtmr_wdog u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (we),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .rst_out_en   (rst_out_en),
        .tmr_irq      (irq),
        .wdog_rst_req (wreq)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[5:2])
            4'd0:  return {26'h0, m_ctl};
            4'd4:  return m_rld[0];
            4'd5:  return m_cnt[0];
            4'd6:  return m_rld[1];
            4'd7:  return m_cnt[1];
            4'd8:  return m_rld[2];
            4'd9:  return m_cnt[2];
            4'd10: return {30'h0, m_flag};
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural model stepped on each rising edge
    always @(posedge clk) begin
        logic [31:0] nc [3];
        logic [2:0]  hit;
        logic        acc;
        logic [3:0]  idx;
        logic [1:0]  clr;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0;
                m_rld[i] = 0;
            end
            m_ctl = 0; m_flag = 0; m_req = 0;
        end else begin
            acc = we && addr[1:0] == 2'b00;
            idx = addr[5:2];
            for (int i = 0; i < 3; i++) begin
                hit[i] = 1'b0;
                nc[i]  = m_cnt[i];
                if (acc && idx == 5 + 2 * i) nc[i] = wdata;
                else if (m_ctl[2*i]) begin
                    if (m_cnt[i] != 0) begin
                        nc[i]  = m_cnt[i] - 1;
                        hit[i] = (m_cnt[i] == 1);
                    end else if (m_ctl[2*i+1]) nc[i] = m_rld[i];
                end
            end
            m_req  = hit[2] && rst_out_en;
            clr    = (acc && idx == 10) ? wdata[1:0] : 2'b00;
            m_flag = (m_flag & ~clr) | hit[1:0];
            for (int i = 0; i < 3; i++) begin
                if (acc && idx == 4 + 2 * i) m_rld[i] = wdata;
                m_cnt[i] = nc[i];
            end
            if (acc && idx == 0) m_ctl = wdata[5:0];
        end
    end

    // Per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " rdata"}, rdata, model_read(addr));
            chk({cur_req, " irq"}, {30'h0, irq}, {30'h0, m_flag});
            chk({cur_req, " wdog req"}, {31'h0, wreq}, {31'h0, m_req});
            if (wreq) wd_pulses++;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        logic [31:0] seq [8];
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: every mapped register reads zero after reset
        cur_req = "R1";
        for (int k = 0; k < 11; k++) begin
            rd(6'(k * 4), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq after reset", {30'h0, irq}, 32'h0);

        // R2: register decode and control width
        cur_req = "R2";
        wr(6'h10, 32'h1234_5678);
        rd(6'h10, v);
        chk("R2 reload0 readback", v, 32'h1234_5678);
        wr(6'h00, 32'hFFFF_FFC0);
        rd(6'h00, v);
        chk("R2 ctl upper bits", v, 32'h0);
        wr(6'h00, 32'h0000_002A);
        rd(6'h00, v);
        chk("R2 ctl readback", v, 32'h2A);

        // R3: single-shot timer0 decrements one per clock
        cur_req = "R3";
        wr(6'h00, 32'h1);
        wr(6'h14, 32'd100);
        rd(6'h14, v);
        rd(6'h14, v2);
        chk("R3 decrement by one", v2, v - 1);

        // R4: reaches zero and stays, irq0 raised
        cur_req = "R4";
        idle(120);
        rd(6'h14, v);
        chk("R4 one-shot holds zero", v, 32'h0);
        chk("R4 irq0 set", {31'h0, irq[0]}, 32'h1);

        // R8: wrong bit does not clear; set beats clear in same cycle
        cur_req = "R8";
        wr(6'h28, 32'h2);
        chk("R8 irq0 sticky", {31'h0, irq[0]}, 32'h1);
        wr(6'h14, 32'd2);
        idle(1);
        wr(6'h28, 32'h1);
        chk("R8 set wins over clear", {31'h0, irq[0]}, 32'h1);
        wr(6'h28, 32'h1);
        chk("R8 W1C clears", {31'h0, irq[0]}, 32'h0);

        // R5: periodic timer1 with period reload+1
        cur_req = "R5";
        wr(6'h00, 32'h0C);
        wr(6'h18, 32'd3);
        wr(6'h1C, 32'd3);
        for (int k = 0; k < 8; k++) rd(6'h1C, seq[k]);
        for (int k = 0; k < 4; k++) chk("R5 period of four", seq[k+4], seq[k]);
        chk("R5 irq1 set", {31'h0, irq[1]}, 32'h1);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h1C, 32'd1);
        idle(2);
        rd(6'h1C, v);
        rd(6'h1C, v2);
        chk("R5 wrap to all ones", v, 32'hFFFF_FFFF);
        chk("R5 inverse increments", ~v2, ~v + 1);

        // R11: timer1 stopped holds while timer0 runs
        cur_req = "R11";
        wr(6'h14, 32'd500);
        wr(6'h00, 32'h1);
        rd(6'h1C, v);
        idle(10);
        rd(6'h1C, v2);
        chk("R11 stopped timer holds", v2, v);

        // R7: control zero stops all counters
        cur_req = "R7";
        wr(6'h24, 32'd1000);
        wr(6'h00, 32'h15);
        idle(5);
        wr(6'h00, 32'h0);
        rd(6'h14, v);
        idle(10);
        rd(6'h14, v2);
        chk("R7 timer0 stopped", v2, v);
        rd(6'h24, v);
        idle(10);
        rd(6'h24, v2);
        chk("R7 watchdog stopped", v2, v);

        // R10: holes and misaligned addresses
        cur_req = "R10";
        rd(6'h14, v);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h15, 32'h0);
        wr(6'h01, 32'h3F);
        rd(6'h04, v2); chk("R10 hole 0x04 zero", v2, 32'h0);
        rd(6'h2C, v2); chk("R10 hole 0x2C zero", v2, 32'h0);
        rd(6'h3C, v2); chk("R10 hole 0x3C zero", v2, 32'h0);
        rd(6'h16, v2); chk("R10 misaligned zero", v2, 32'h0);
        rd(6'h14, v2); chk("R10 timer0 untouched", v2, v);
        rd(6'h00, v2); chk("R10 ctl untouched", v2, 32'h0);

        // R6 and R9: watchdog refresh, expiry and gating
        cur_req = "R6";
        rst_out_en = 1'b1;
        wd_pulses = 0;
        wr(6'h24, 32'd77);
        rd(6'h24, v);
        chk("R6 count write", v, 32'd77);
        wr(6'h24, 32'd30);
        wr(6'h00, 32'h10);
        for (int k = 0; k < 6; k++) begin
            idle(10);
            wr(6'h24, 32'd30);
        end
        chk("R6 refresh prevents request", wd_pulses, 0);
        cur_req = "R9";
        idle(40);
        chk("R9 one single-cycle request", wd_pulses, 1);
        rd(6'h24, v);
        chk("R9 watchdog at zero", v, 32'h0);
        rst_out_en = 1'b0;
        wr(6'h24, 32'd5);
        idle(20);
        chk("R9 gated request", wd_pulses, 1);

        finish_run();
    end

endmodule